// File: doc/BRIEF.md
# Dual-Port Address Collision Busy Arbiter

This block sits beside a shared two-port memory and watches the enable and address inputs of both ports. When both ports are enabled at the same location at the same time, it lets one of them proceed and tells the other, through an active-low busy signal, that the location is taken. The busied port's write strobe is forced inactive inside the block, so a collision can never corrupt the shared word, whatever the busy pin itself is doing outside.

Arrival order decides the winner. Each port's enable and address are sampled at every clock edge. A port counts as fresh in a cycle when either value differs from the last sample. In a new collision the port that was not fresh arrived earlier and wins. If both are fresh, or neither is, the left port wins. The winner keeps its grant while its own enable and address stay unchanged. A mode input selects master operation, where the block drives both busy pins push-pull, or slave operation, where the busy pins are inputs from another arbiter and a low level on them inhibits that port's writes.

Top module: `dpa_collision_arbiter`

## Requirements
- R1: When either port is disabled (enable high) or the two addresses differ, both busy outputs are high.
- R2: In a new collision, where exactly one port is fresh (its enable or address differs from the value sampled at the previous clock edge), the fresh port gets busy low and the other port's busy stays high, in the same cycle the collision appears.
- R3: In a new collision where both ports are fresh, the left port wins and right busy goes low. The two busy outputs are never low together.
- R4: While the collision persists, the winner keeps its grant as long as its own enable and address are unchanged, even if the losing port changes its write strobe or re-enables.
- R5: When the winner releases (enable high or address changed), the loser's busy returns high in that same cycle. If the former winner then comes back to the same address, it is the fresh port and receives busy low.
- R6: In master mode (mode input high), the write strobe of the port whose busy output is low is forced high. The other port's strobe passes through unchanged, and the busy input pins have no effect.
- R7: In slave mode (mode input low), both busy output enables are low and both busy outputs read high. Each port's write strobe is forced high while that port's busy input is low and passes through otherwise.
- R8: In master mode both busy output enables are high, so the pins are driven at both levels (push-pull).
- R9: After reset, with both ports disabled, both busy outputs are high and the write strobes pass through. The input samples start as disabled, so the first enable after reset counts as fresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| master_mode | input | 1 | 1 = master (drive busy pins), 0 = slave (busy pins are inputs) |
| left_en_n | input | 1 | Left port enable, active low |
| left_addr | input | ADDR_W | Left port address |
| left_we_n | input | 1 | Left port write strobe, active low |
| left_busy_in_n | input | 1 | Left busy pin level as received in slave mode |
| left_busy_n | output | 1 | Left busy, active low |
| left_busy_oe | output | 1 | Output enable for the left busy pin |
| left_we_gated_n | output | 1 | Left write strobe after collision gating, active low |
| right_en_n | input | 1 | Right port enable, active low |
| right_addr | input | ADDR_W | Right port address |
| right_we_n | input | 1 | Right port write strobe, active low |
| right_busy_in_n | input | 1 | Right busy pin level as received in slave mode |
| right_busy_n | output | 1 | Right busy, active low |
| right_busy_oe | output | 1 | Output enable for the right busy pin |
| right_we_gated_n | output | 1 | Right write strobe after collision gating, active low |

## Verification
The bench runs with a 3-bit address. A full sweep of all 64 address pairs first enables the left port alone and then adds the right port. This separates a genuine collision from a near miss and confirms that the later arrival is the one busied. Directed sequences then cover a simultaneous arrival, both ports moving together while colliding, the loser toggling its strobe while the winner holds, the winner releasing and returning, and slave operation with the busy inputs at both levels, each against the same write strobes. A long pseudo-random stream then mixes modes, enables, strobes and busy inputs over the small address space, so that held grants, hand-overs and ties occur in many orders.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned LEFT_IDX  = 0;
  localparam int unsigned RIGHT_IDX = 1;
endpackage

// File: rtl/dpa_rst_sync.sv
module dpa_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dpa_port_track.sv
// Samples one port's enable and address each edge and flags a cycle in
// which either differs from the previous sample (the port is "fresh").
module dpa_port_track #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              fresh
);
  logic              en_n_q, en_n_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              smp_en;

  always_comb begin
    en_n_d = en_n;
    addr_d = addr;
    fresh  = (en_n != en_n_q) || (addr != addr_q);
    smp_en = fresh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_n_q <= 1'b1;
      addr_q <= '0;
    end else if (smp_en) begin
      en_n_q <= en_n_d;
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/dpa_arb_core.sv
// Collision compare plus owner state. The grant is resolved in the same
// cycle the inputs present so that a write in the first colliding cycle
// is already gated.
module dpa_arb_core
  import dpa_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_fresh,
  input  logic              r_en_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_fresh,
  output owner_e            grant
);
  owner_e owner_q, owner_d;
  logic   collide;
  logic   keep_left, keep_right;
  logic   own_en;

  always_comb begin
    collide    = !l_en_n && !r_en_n && (l_addr == r_addr);
    keep_left  = (owner_q == OWN_LEFT)  && !l_fresh;
    keep_right = (owner_q == OWN_RIGHT) && !r_fresh;
    if (!collide)                   owner_d = OWN_NONE;
    else if (keep_left)             owner_d = OWN_LEFT;
    else if (keep_right)            owner_d = OWN_RIGHT;
    else if (l_fresh && !r_fresh)   owner_d = OWN_RIGHT;
    else                            owner_d = OWN_LEFT;
    own_en = (owner_d != owner_q);
    grant  = owner_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      owner_q <= OWN_NONE;
    else if (own_en) owner_q <= owner_d;
  end
endmodule

// File: rtl/dpa_busy_gate.sv
// Per-port busy drive and write gating, selected by master/slave mode.
module dpa_busy_gate
  import dpa_pkg::*;
#(
  parameter int unsigned PORT_IDX = 0
) (
  input  logic   master_mode,
  input  owner_e grant,
  input  logic   we_n,
  input  logic   busy_in_n,
  output logic   busy_n,
  output logic   busy_oe,
  output logic   we_gated_n
);
  logic lost;

  generate
    if (PORT_IDX == LEFT_IDX) begin : g_left
      assign lost = (grant == OWN_RIGHT);
    end else begin : g_right
      assign lost = (grant == OWN_LEFT);
    end
  endgenerate

  always_comb begin
    busy_oe = master_mode;
    busy_n  = !(master_mode && lost);
    if (master_mode) we_gated_n = we_n || lost;
    else             we_gated_n = we_n || !busy_in_n;
  end
endmodule

// File: rtl/dpa_collision_arbiter.sv
module dpa_collision_arbiter
  import dpa_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              left_en_n,
  input  logic [ADDR_W-1:0] left_addr,
  input  logic              left_we_n,
  input  logic              left_busy_in_n,
  output logic              left_busy_n,
  output logic              left_busy_oe,
  output logic              left_we_gated_n,
  input  logic              right_en_n,
  input  logic [ADDR_W-1:0] right_addr,
  input  logic              right_we_n,
  input  logic              right_busy_in_n,
  output logic              right_busy_n,
  output logic              right_busy_oe,
  output logic              right_we_gated_n
);
  logic              rst_int_n;
  logic              en_n_a   [NUM_PORTS];
  logic [ADDR_W-1:0] addr_a   [NUM_PORTS];
  logic              we_n_a   [NUM_PORTS];
  logic              bin_n_a  [NUM_PORTS];
  logic              fresh_a  [NUM_PORTS];
  logic              bout_n_a [NUM_PORTS];
  logic              boe_a    [NUM_PORTS];
  logic              weg_n_a  [NUM_PORTS];
  owner_e            grant;

  assign en_n_a[LEFT_IDX]   = left_en_n;
  assign en_n_a[RIGHT_IDX]  = right_en_n;
  assign addr_a[LEFT_IDX]   = left_addr;
  assign addr_a[RIGHT_IDX]  = right_addr;
  assign we_n_a[LEFT_IDX]   = left_we_n;
  assign we_n_a[RIGHT_IDX]  = right_we_n;
  assign bin_n_a[LEFT_IDX]  = left_busy_in_n;
  assign bin_n_a[RIGHT_IDX] = right_busy_in_n;

  dpa_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      dpa_port_track #(.ADDR_W(ADDR_W)) track_i (
        .clk   (clk),
        .rst_n (rst_int_n),
        .en_n  (en_n_a[p]),
        .addr  (addr_a[p]),
        .fresh (fresh_a[p])
      );
      dpa_busy_gate #(.PORT_IDX(p)) gate_i (
        .master_mode (master_mode),
        .grant       (grant),
        .we_n        (we_n_a[p]),
        .busy_in_n   (bin_n_a[p]),
        .busy_n      (bout_n_a[p]),
        .busy_oe     (boe_a[p]),
        .we_gated_n  (weg_n_a[p])
      );
    end
  endgenerate

  dpa_arb_core #(.ADDR_W(ADDR_W)) core_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .l_en_n  (left_en_n),
    .l_addr  (left_addr),
    .l_fresh (fresh_a[LEFT_IDX]),
    .r_en_n  (right_en_n),
    .r_addr  (right_addr),
    .r_fresh (fresh_a[RIGHT_IDX]),
    .grant   (grant)
  );

  assign left_busy_n      = bout_n_a[LEFT_IDX];
  assign left_busy_oe     = boe_a[LEFT_IDX];
  assign left_we_gated_n  = weg_n_a[LEFT_IDX];
  assign right_busy_n     = bout_n_a[RIGHT_IDX];
  assign right_busy_oe    = boe_a[RIGHT_IDX];
  assign right_we_gated_n = weg_n_a[RIGHT_IDX];
endmodule

// File: rtl/dpa_collision_chk.sv
module dpa_collision_chk #(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_mode,
  input logic              left_en_n,
  input logic [ADDR_W-1:0] left_addr,
  input logic              left_we_n,
  input logic              left_busy_in_n,
  input logic              left_busy_n,
  input logic              left_busy_oe,
  input logic              left_we_gated_n,
  input logic              right_en_n,
  input logic [ADDR_W-1:0] right_addr,
  input logic              right_we_n,
  input logic              right_busy_in_n,
  input logic              right_busy_n,
  input logic              right_busy_oe,
  input logic              right_we_gated_n
);
  logic coll;
  assign coll = !left_en_n && !right_en_n && (left_addr == right_addr);

  AST_IDLE_BUSY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !coll |-> (left_busy_n && right_busy_n)); // R1
  AST_ONE_SIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && coll) |-> (left_busy_n != right_busy_n)); // R2
  AST_NEVER_BOTH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (left_busy_n || right_busy_n)); // R3
  AST_HOLD_LEFT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !right_busy_n) |=>
      (!(master_mode && coll && $stable(left_en_n) && $stable(left_addr)) || !right_busy_n)); // R4
  AST_HOLD_RIGHT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !left_busy_n) |=>
      (!(master_mode && coll && $stable(right_en_n) && $stable(right_addr)) || !left_busy_n)); // R4
  AST_LEFT_WRITE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !left_busy_n) |-> left_we_gated_n); // R6
  AST_RIGHT_WRITE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !right_busy_n) |-> right_we_gated_n); // R6
  AST_SLAVE_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && (!left_busy_in_n || left_we_n)) |-> left_we_gated_n); // R7
  AST_SLAVE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (!left_busy_oe && !right_busy_oe)); // R7
  AST_MASTER_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode |-> (left_busy_oe && right_busy_oe)); // R8
  AST_PASS_UNBUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && right_busy_n) |-> (right_we_gated_n == right_we_n)); // R6
endmodule

bind dpa_collision_arbiter dpa_collision_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .master_mode      (master_mode),
  .left_en_n        (left_en_n),
  .left_addr        (left_addr),
  .left_we_n        (left_we_n),
  .left_busy_in_n   (left_busy_in_n),
  .left_busy_n      (left_busy_n),
  .left_busy_oe     (left_busy_oe),
  .left_we_gated_n  (left_we_gated_n),
  .right_en_n       (right_en_n),
  .right_addr       (right_addr),
  .right_we_n       (right_we_n),
  .right_busy_in_n  (right_busy_in_n),
  .right_busy_n     (right_busy_n),
  .right_busy_oe    (right_busy_oe),
  .right_we_gated_n (right_we_gated_n)
);

// File: tb/dpa_collision_arbiter_tb_top.sv
`timescale 1ns/1ps
module dpa_collision_arbiter_tb_top;
  localparam int unsigned AW = 3;
  localparam int unsigned WATCHDOG_NS = 1_000_000;

  logic          clk;
  logic          rst_n;
  logic          master_mode;
  logic          left_en_n, right_en_n;
  logic [AW-1:0] left_addr, right_addr;
  logic          left_we_n, right_we_n;
  logic          left_busy_in_n, right_busy_in_n;
  logic          left_busy_n, right_busy_n;
  logic          left_busy_oe, right_busy_oe;
  logic          left_we_gated_n, right_we_gated_n;

  int unsigned n_vec;
  int unsigned n_bad;
  bit          done;

  // bench model state: last sampled inputs and current owner (0 none, 1 L, 2 R)
  logic          m_len, m_ren;
  logic [AW-1:0] m_la, m_ra;
  int            m_own;
  logic [31:0]   lfsr;

  dpa_collision_arbiter #(.ADDR_W(AW)) dut_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .master_mode      (master_mode),
    .left_en_n        (left_en_n),
    .left_addr        (left_addr),
    .left_we_n        (left_we_n),
    .left_busy_in_n   (left_busy_in_n),
    .left_busy_n      (left_busy_n),
    .left_busy_oe     (left_busy_oe),
    .left_we_gated_n  (left_we_gated_n),
    .right_en_n       (right_en_n),
    .right_addr       (right_addr),
    .right_we_n       (right_we_n),
    .right_busy_in_n  (right_busy_in_n),
    .right_busy_n     (right_busy_n),
    .right_busy_oe    (right_busy_oe),
    .right_we_gated_n (right_we_gated_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic cmp(input string tag, input string what, input logic act, input logic exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b (vector %0d)", tag, what, act, exp, n_vec);
    end
  endtask

  task automatic apply(input logic ms, input logic len, input logic [AW-1:0] la,
                       input logic lwe, input logic lbi, input logic ren,
                       input logic [AW-1:0] ra, input logic rwe, input logic rbi,
                       input string tag);
    logic lf, rf, coll;
    int   own;
    @(negedge clk);
    master_mode = ms;
    left_en_n = len;  left_addr = la;  left_we_n = lwe;  left_busy_in_n = lbi;
    right_en_n = ren; right_addr = ra; right_we_n = rwe; right_busy_in_n = rbi;
    #1;
    lf   = (len != m_len) || (la != m_la);
    rf   = (ren != m_ren) || (ra != m_ra);
    coll = !len && !ren && (la == ra);
    if (!coll)                 own = 0;
    else if (m_own == 1 && !lf) own = 1;
    else if (m_own == 2 && !rf) own = 2;
    else if (lf && !rf)         own = 2;
    else                        own = 1;
    n_vec++;
    cmp(tag, "left_busy_n",  left_busy_n,  !(ms && own == 2));
    cmp(tag, "right_busy_n", right_busy_n, !(ms && own == 1));
    cmp(tag, "left_busy_oe", left_busy_oe, ms);
    cmp(tag, "right_busy_oe", right_busy_oe, ms);
    cmp(tag, "left_we_gated_n",  left_we_gated_n,  ms ? (lwe || own == 2) : (lwe || !lbi));
    cmp(tag, "right_we_gated_n", right_we_gated_n, ms ? (rwe || own == 1) : (rwe || !rbi));
    m_len = len; m_ren = ren; m_la = la; m_ra = ra; m_own = own;
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(WATCHDOG_NS);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; done = 1'b0;
    m_len = 1'b1; m_ren = 1'b1; m_la = '0; m_ra = '0; m_own = 0;
    lfsr = 32'h1234_5678;
    rst_n = 1'b0; master_mode = 1'b1;
    left_en_n = 1'b1; right_en_n = 1'b1; left_addr = '0; right_addr = '0;
    left_we_n = 1'b1; right_we_n = 1'b1; left_busy_in_n = 1'b1; right_busy_in_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: idle after reset
    apply(1, 1, 0, 0, 1, 1, 0, 0, 1, "R9");
    // R2: left first at 5, right joins later and is busied; R6 gating
    apply(1, 0, 5, 0, 1, 1, 0, 0, 1, "R1");
    apply(1, 0, 5, 0, 1, 0, 5, 0, 1, "R2");
    // R4: loser toggles strobe, winner holds
    apply(1, 0, 5, 0, 1, 0, 5, 1, 1, "R4");
    // R1: loser moves off, then back (fresh, busied again)
    apply(1, 0, 5, 0, 1, 0, 6, 0, 1, "R1");
    apply(1, 0, 5, 0, 1, 0, 5, 0, 1, "R2");
    // R4: loser re-enables while winner holds
    apply(1, 0, 5, 0, 1, 1, 5, 0, 1, "R1");
    apply(1, 0, 5, 0, 1, 0, 5, 0, 1, "R4");
    // R5: winner releases, loser freed; winner returns and is busied
    apply(1, 1, 5, 0, 1, 0, 5, 0, 1, "R5");
    apply(1, 0, 5, 0, 1, 0, 5, 0, 1, "R5");
    apply(1, 0, 5, 0, 0, 0, 5, 0, 0, "R6");
    // R3: both move together while right owns; tie to left
    apply(1, 0, 1, 0, 1, 0, 1, 0, 1, "R3");
    // R3: simultaneous arrival from idle
    apply(1, 1, 2, 1, 1, 1, 2, 1, 1, "R1");
    apply(1, 0, 2, 0, 1, 0, 2, 0, 1, "R3");
    // R6: busy inputs ignored in master mode
    apply(1, 0, 3, 0, 0, 0, 4, 0, 0, "R6");
    // R7: slave mode, collision present, busy inputs both levels
    apply(0, 0, 4, 0, 1, 0, 4, 0, 1, "R7");
    apply(0, 0, 4, 0, 0, 0, 4, 0, 1, "R7");
    apply(0, 0, 4, 1, 0, 0, 4, 0, 0, "R7");
    // R8: back to master with collision held
    apply(1, 0, 4, 0, 1, 0, 4, 0, 1, "R8");

    // exhaustive pair sweep: left first, right joins, both release
    for (int a = 0; a < (1 << AW); a++) begin
      for (int b = 0; b < (1 << AW); b++) begin
        apply(1, 0, AW'(a), 0, 1, 1, 0, 0, 1, "R1");
        apply(1, 0, AW'(a), 0, 1, 0, AW'(b), 0, 1, "R2");
        apply(1, 1, 0, 1, 1, 1, 0, 1, 1, "R5");
      end
    end

    // pseudo-random stream
    for (int i = 0; i < 4000; i++) begin
      lfsr = step(lfsr);
      apply(lfsr[1:0] != 2'b00, lfsr[4:2] == 3'b000, lfsr[7:5], lfsr[8], lfsr[9],
            lfsr[12:10] == 3'b000, (lfsr[13] ? lfsr[7:5] : lfsr[16:14]),
            lfsr[17], lfsr[18], "R4");
    end

    done = 1'b1;
    finish_run();
  end
endmodule